// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter built from 4-bit slices. It counts up or down on the rising clock edge. Each slice has two active-low count enables. The first is a shared level that all slices see. The second is a chain enable that each slice also folds into its own active-low terminal-count output. Because of this, slices can be chained with no extra gating: each slice's terminal-count output drives the chain enable of the next slice.

An active-low synchronous load presets the whole chain from a parallel data word. It overrides counting. An active-low synchronous reset clears the count. The top level instantiates `STAGES` slices, so the chain behaves as one `STAGES*DIG_W`-bit counter. The last slice's terminal-count output is brought out, so the whole chain can in turn feed a further stage.

Top module: `updn_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge, `q` becomes all zeros after that edge. Reset overrides load and counting.
- R2: With `rst_n` high and `load_n` low at a rising edge, `q` takes `din` after that edge. This holds whatever the levels of `cnt_en_n`, `chain_en_n` and `dir_up`.
- R3: With `load_n` high and either `cnt_en_n` or `chain_en_n` high at a rising edge, `q` keeps its value.
- R4: With `load_n`, `cnt_en_n` and `chain_en_n` all at their counting levels (high, low, low) and `dir_up` high (1 = up), `q` increments by one at each edge. It wraps from all ones to zero.
- R5: Under the same enable conditions with `dir_up` low (0 = down), `q` decrements by one at each edge. It wraps from zero to all ones.
- R6: `carry_n` is combinational. It is low exactly when `chain_en_n` is low and `q` is all ones (with `dir_up` = 1) or all zeros (with `dir_up` = 0). Otherwise it is high.
- R7: When each slice's terminal-count output drives the next slice's chain enable, and all slices share `cnt_en_n`, the `STAGES*DIG_W`-bit `q` matches a single counter of that width in both directions, including across the carry and borrow between slices.
- R8: A change on `load_n`, `cnt_en_n`, `chain_en_n` or `dir_up` between edges leaves `q` unchanged until the next rising edge. Only the levels present at that edge decide the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en_n | input | 1 | Active-low count enable shared by every slice |
| chain_en_n | input | 1 | Active-low chain enable into slice 0; also gates `carry_n` |
| load_n | input | 1 | Active-low synchronous parallel load |
| dir_up | input | 1 | Count direction: 1 counts up, 0 counts down |
| din | input | STAGES*DIG_W | Parallel preset data |
| q | output | STAGES*DIG_W | Current count |
| carry_n | output | 1 | Active-low terminal count of the whole chain |

## Verification
A corrupted slice register appears on `q` one edge after the faulty update. From then on, every later count differs from the reference model.

A fault in the terminal-count or chaining logic has two signs. `carry_n` goes wrong at once, within the same cycle. The upper slice then steps at the wrong moment, which shows on the next edge where the lower slice wraps.

Holds, loads and mid-cycle control glitches are each compared against the model on the edge that follows them.

// File: rtl/updn_pkg.sv
// Package: shared operation type and the control decode for one counter slice.
// Assumes active-low load and enables; load outranks counting.
package updn_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } op_e;

    // Picks the edge action from the control levels (load first, then both enables).
    function automatic op_e pick_op(input logic ld_n, input logic p_n,
                                    input logic t_n, input logic up);
        if (!ld_n)
            return OP_LOAD;
        else if (!p_n && !t_n)
            return up ? OP_INC : OP_DEC;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/updn_term.sv
// Module: terminal-count detector for one slice.
// Drives an active-low flag when the chain enable is low and the count sits at
// the end value for the current direction (all ones up, all zeros down).
// Purely combinational; assumes cnt comes straight from the slice register.
module updn_term #(
    parameter int DIG_W = 4
) (
    input  logic [DIG_W-1:0] cnt,
    input  logic             up,
    input  logic             en_t_n,
    output logic             tc_n
);

    logic at_end;

    // Selects the end value that matches the direction.
    always_comb at_end = up ? (&cnt) : ~(|cnt);

    // Gates the end-of-range flag with the chain enable.
    always_comb tc_n = ~(~en_t_n & at_end);

endmodule

// File: rtl/updn_stage.sv
// Module: one presettable up/down counter slice.
// Every state change happens on the rising edge; reset is synchronous and
// active-low and outranks load, and load outranks counting.
// Assumes the inputs meet setup and hold around the edge.
module updn_stage
    import updn_pkg::*;
#(
    parameter int DIG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_p_n,
    input  logic             en_t_n,
    input  logic             ld_n,
    input  logic             up,
    input  logic [DIG_W-1:0] d,
    output logic [DIG_W-1:0] q,
    output logic             tc_n
);

    localparam logic [DIG_W-1:0] ONE = DIG_W'(1);

    op_e              op;
    logic [DIG_W-1:0] cnt;

    // Decodes the control levels into one edge action.
    always_comb op = pick_op(ld_n, en_p_n, en_t_n, up);

    // Updates the slice register on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else begin
            case (op)
                OP_LOAD: cnt <= d;
                OP_INC:  cnt <= cnt + ONE;
                OP_DEC:  cnt <= cnt - ONE;
                default: cnt <= cnt;
            endcase
        end
    end

    // Brings the register out.
    always_comb q = cnt;

    updn_term #(.DIG_W(DIG_W)) u_term (
        .cnt    (cnt),
        .up     (up),
        .en_t_n (en_t_n),
        .tc_n   (tc_n)
    );

    // R1
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> q == $past(d));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && (en_p_n || en_t_n)) |=> $stable(q));

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !en_p_n && !en_t_n && up) |=> q == DIG_W'($past(q) + ONE));

    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !en_p_n && !en_t_n && !up) |=> q == DIG_W'($past(q) - ONE));

    // R6
    carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_n |-> (!en_t_n && (q == '0 || q == '1)));

endmodule

// File: rtl/updn_chain.sv
// Module: top level that chains STAGES slices into one wide up/down counter.
// Each slice's terminal-count output feeds the next slice's chain enable; the
// shared enable, load and direction go to every slice.
// Assumes STAGES >= 1; the chain's carry leaves from the last slice.
module updn_chain #(
    parameter int STAGES = 2,
    parameter int DIG_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cnt_en_n,
    input  logic                      chain_en_n,
    input  logic                      load_n,
    input  logic                      dir_up,
    input  logic [STAGES*DIG_W-1:0]   din,
    output logic [STAGES*DIG_W-1:0]   q,
    output logic                      carry_n
);

    localparam int W = STAGES * DIG_W;
    localparam logic [W-1:0] ONE_W = W'(1);

    logic [STAGES:0] t_link;

    // Feeds the external chain enable into slice 0.
    always_comb t_link[0] = chain_en_n;

    for (genvar g = 0; g < STAGES; g++) begin : g_slice
        updn_stage #(.DIG_W(DIG_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_p_n (cnt_en_n),
            .en_t_n (t_link[g]),
            .ld_n   (load_n),
            .up     (dir_up),
            .d      (din[g*DIG_W +: DIG_W]),
            .q      (q[g*DIG_W +: DIG_W]),
            .tc_n   (t_link[g+1])
        );
    end

    // Takes the chain carry from the last slice.
    always_comb carry_n = t_link[STAGES];

    // R7
    wide_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && dir_up) |=> q == W'($past(q) + ONE_W));

    // R7
    wide_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n && !chain_en_n && !dir_up) |=> q == W'($past(q) - ONE_W));

    // R6
    wide_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (dir_up ? (q == '1) : (q == '0)));

endmodule

// File: tb/sim_updn_chain.sv
// Bench: scoreboard for updn_chain. The driver applies inputs at the falling
// edge, checks the carry, and queues the count the model predicts after the
// next rising edge; a monitor pops and compares just after each rising edge.
module sim_updn_chain;

    localparam int STAGES = 2;
    localparam int DIG_W  = 4;
    localparam int W      = STAGES * DIG_W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en_n = 1'b1;
    logic         chain_en_n = 1'b1;
    logic         load_n = 1'b1;
    logic         dir_up = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         carry_n;

    int total = 0;
    int bad = 0;

    logic [W-1:0] mdl = '0;
    bit           known = 1'b0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    updn_chain #(.STAGES(STAGES), .DIG_W(DIG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n),
        .load_n(load_n), .dir_up(dir_up), .din(din), .q(q), .carry_n(carry_n)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Monitor: compares the count just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (q !== e) begin
                bad++;
                $display("FAIL %s q got=%h exp=%h", t, q, e);
            end
        end
    end

    // Model of the next count from the levels at an edge.
    function automatic logic [W-1:0] nxt(input logic r, input logic p, input logic t,
                                         input logic ld, input logic up,
                                         input logic [W-1:0] d, input logic [W-1:0] cur);
        if (!r) return '0;
        if (!ld) return d;
        if (!p && !t) return up ? cur + W'(1) : cur - W'(1);
        return cur;
    endfunction

    task automatic chk_carry(input string tag);
        logic e;
        e = ~(~chain_en_n & (dir_up ? (mdl == '1) : (mdl == '0)));
        total++;
        if (carry_n !== e) begin
            bad++;
            $display("FAIL %s carry_n got=%b exp=%b", tag, carry_n, e);
        end
    endtask

    // Driver: one cycle of stimulus plus its queued expectation.
    task automatic step(input logic r, input logic p, input logic t, input logic ld,
                        input logic up, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        rst_n = r; cnt_en_n = p; chain_en_n = t; load_n = ld; dir_up = up; din = d;
        #1;
        if (known) chk_carry("R6");
        mdl = nxt(r, p, t, ld, up, d, mdl);
        known = 1'b1;
        exp_q.push_back(mdl);
        tag_q.push_back(tag);
    endtask

    // R8: pulse controls inside a cycle; q must not move before the edge.
    task automatic glitch(input logic [W-1:0] d);
        @(negedge clk);
        load_n = 1'b0; din = d; cnt_en_n = 1'b0; chain_en_n = 1'b0; dir_up = ~dir_up;
        #1;
        total++;
        if (q !== mdl) begin
            bad++;
            $display("FAIL R8 q moved between edges got=%h exp=%h", q, mdl);
        end
        #1;
        load_n = 1'b1; cnt_en_n = 1'b1;
        mdl = nxt(1'b1, 1'b1, chain_en_n, 1'b1, dir_up, d, mdl);
        exp_q.push_back(mdl);
        tag_q.push_back("R8");
    endtask

    // Watchdog: counts an expiry as a failure and still reports.
    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h77, "R1");
        // load with enables off, and with enables on
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, "R2");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, "R2");
        // holds
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R3");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R3");
        // up across a slice carry and the full wrap
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h0E, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R7");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFD, "R2");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R4");
        // carry held off by chain enable at terminal count
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, "R2");
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R6");
        // down across the full wrap and a slice borrow
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h02, "R2");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R5");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R7");
        // long up run against the model
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, "R4");
        // mid-cycle control changes
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3");
        glitch(8'h5A);
        glitch(8'hC3);
        // reset overrides a pending load
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h99, "R1");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R3");
        @(negedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule